// File: doc/BRIEF.md
# Single-Bit Manipulation and Carry Logic Unit

This unit performs one single-bit operation per request on a byte-wide operand. A bit position selects one bit of the operand. The unit can force that bit to one, force it to zero, flip it, or test it into the zero flag. It can also treat the carry flag as a one-bit accumulator: it loads the bit into carry, stores carry into the bit, or folds the bit into carry with AND, OR or XOR. Each of these carry operations also has a form that uses the complement. The surrounding datapath fetches the operand, presents it together with the current carry, and writes back whatever the unit reports as changed.

A request is presented for one cycle with `op_valid`. The result appears on the registered outputs in the next cycle, qualified by `res_valid`. A small two-state controller tracks whether a result is being presented. `ST_IDLE` means no result is on the outputs. `ST_RESULT` means the outputs carry the result of the request taken on the previous edge. Its transitions are named as follows:
- `ST_IDLE -> ST_RESULT` (accept) on `op_valid`.
- `ST_RESULT -> ST_RESULT` (chain) on another `op_valid`.
- `ST_RESULT -> ST_IDLE` (drain) when no request follows.
- `ST_IDLE -> ST_IDLE` (wait) otherwise.

Operation codes: 0 set, 1 clear, 2 flip, 3 test, 4 load, 5 inverted load, 6 store, 7 inverted store, 8 AND, 9 inverted AND, 10 OR, 11 inverted OR, 12 XOR, 13 inverted XOR. Codes 14 and 15 are reserved. For codes 4 to 13, bit 0 of the code selects the inverted form.

Top module: `bitu_core`

## Requirements
- R1: After reset, `res_valid`, `res_wr`, `res_c_upd` and `res_z_upd` are 0. `res_valid` is 1 in the cycle after each cycle with `op_valid` high, and 0 in the cycle after a cycle with `op_valid` low; back-to-back requests give back-to-back results.
- R2: Only the low three bits of `bit_idx` select the bit (mask = 1 shifted left by `bit_idx` modulo 8); the upper bits have no effect.
- R3: Codes 0, 1 and 2 set, clear and flip the selected bit respectively, leave the other bits unchanged, assert `res_wr` and leave carry and zero not updated.
- R4: Code 3 (test) asserts `res_z_upd` with `res_z` equal to the complement of the selected bit, and keeps `res_wr` at 0.
- R5: Code 4 copies the selected bit into `res_c` and code 5 copies its complement; both assert `res_c_upd` and keep `res_wr` at 0.
- R6: Codes 6 and 7 write the selected bit from `c_in` (code 6) or from the complement of `c_in` (code 7), leave the other bits unchanged, and assert `res_wr` without updating carry.
- R7: Codes 8/9, 10/11 and 12/13 place in `res_c` the AND, OR and XOR of `c_in` with the selected bit (even code) or with its complement (odd code), assert `res_c_upd` and keep `res_wr` at 0.
- R8: When `res_wr` is 0, `res_byte` equals the operand of the request; when `res_c_upd` is 0, `res_c` equals the `c_in` of the request.
- R9: Reserved codes 14 and 15 assert none of `res_wr`, `res_c_upd` and `res_z_upd`.
- R10: At most one of `res_wr`, `res_c_upd` and `res_z_upd` is 1 in any cycle, and none is 1 while `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe for one operation |
| op_code | input | 4 | Operation code (see table above) |
| opnd | input | DATA_W (8) | Operand byte |
| bit_idx | input | IDX_W (4) | Bit position; low three bits used |
| c_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result present on the outputs |
| res_byte | output | DATA_W (8) | Updated byte, or operand if not written |
| res_wr | output | 1 | Byte must be written back |
| res_c | output | 1 | New carry value |
| res_c_upd | output | 1 | Carry is updated |
| res_z | output | 1 | New zero flag value |
| res_z_upd | output | 1 | Zero flag is updated |

## Verification
On every cycle, the assertions check the result timing relative to the strobe and the exclusivity of the three update enables. They also check that a result never changes more than one bit of the operand, and that a result without write-back or carry update passes the operand and carry through. The silence of the reserved codes is checked the same way. The per-operation value of the changed bit, the complement forms, the wrap of out-of-range indices, and the test flag polarity need known operand and index patterns. Only the bench's directed scenarios show these.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } bitu_state_e;

    typedef enum logic [3:0] {
        CL_SET,
        CL_CLR,
        CL_FLIP,
        CL_TEST,
        CL_LOAD,
        CL_STORE,
        CL_AND,
        CL_OR,
        CL_XOR,
        CL_NOP
    } bitu_cls_e;

endpackage

// File: rtl/bitu_decode.sv
module bitu_decode
    import bitu_pkg::*;
(
    input  logic [3:0] op_code,
    output bitu_cls_e  cls,
    output logic       inv
);
    // Codes 4..13 come in pairs; the odd member is the complement form.
    always_comb begin
        inv = op_code[0];
        case (op_code)
            4'd0:         cls = CL_SET;
            4'd1:         cls = CL_CLR;
            4'd2:         cls = CL_FLIP;
            4'd3:         cls = CL_TEST;
            4'd4, 4'd5:   cls = CL_LOAD;
            4'd6, 4'd7:   cls = CL_STORE;
            4'd8, 4'd9:   cls = CL_AND;
            4'd10, 4'd11: cls = CL_OR;
            4'd12, 4'd13: cls = CL_XOR;
            default:      cls = CL_NOP;
        endcase
    end
endmodule

// File: rtl/bitu_alu.sv
module bitu_alu
    import bitu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  bitu_cls_e         cls,
    input  logic              inv,
    input  logic [DATA_W-1:0] opnd,
    input  logic [SEL_W-1:0]  sel,
    input  logic              c_in,
    output logic [DATA_W-1:0] nbyte,
    output logic              wr,
    output logic              nc,
    output logic              c_upd,
    output logic              nz,
    output logic              z_upd
);
    logic [DATA_W-1:0] mask;
    logic              bit_v;
    logic              bit_s;
    logic              src_c;

    // One-hot mask: a single one placed at the selected position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (sel == SEL_W'(g));
    end

    assign bit_v = |(opnd & mask);
    assign bit_s = bit_v ^ inv;
    assign src_c = c_in ^ inv;

    always_comb begin
        nbyte = opnd;
        wr    = 1'b0;
        nc    = c_in;
        c_upd = 1'b0;
        nz    = 1'b0;
        z_upd = 1'b0;
        unique case (cls)
            CL_SET:   begin nbyte = opnd | mask;  wr = 1'b1; end
            CL_CLR:   begin nbyte = opnd & ~mask; wr = 1'b1; end
            CL_FLIP:  begin nbyte = opnd ^ mask;  wr = 1'b1; end
            CL_TEST:  begin nz = ~bit_v; z_upd = 1'b1; end
            CL_LOAD:  begin nc = bit_s; c_upd = 1'b1; end
            CL_STORE: begin
                nbyte = (opnd & ~mask) | (src_c ? mask : '0);
                wr    = 1'b1;
            end
            CL_AND:   begin nc = bit_s & c_in; c_upd = 1'b1; end
            CL_OR:    begin nc = bit_s | c_in; c_upd = 1'b1; end
            CL_XOR:   begin nc = bit_s ^ c_in; c_upd = 1'b1; end
            CL_NOP:   begin end
        endcase
    end
endmodule

// File: rtl/bitu_core.sv
module bitu_core
    import bitu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              c_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_byte,
    output logic              res_wr,
    output logic              res_c,
    output logic              res_c_upd,
    output logic              res_z,
    output logic              res_z_upd
);
    localparam int SEL_W = $clog2(DATA_W);

    bitu_state_e       state, state_nx;
    bitu_cls_e         cls;
    logic              inv;
    logic [DATA_W-1:0] nbyte;
    logic              wr, nc, c_upd, nz, z_upd;
    logic              unused_idx;

    // Upper index bits are deliberately ignored (index wraps modulo width).
    assign unused_idx = ^bit_idx;

    bitu_decode u_dec (
        .op_code (op_code),
        .cls     (cls),
        .inv     (inv)
    );

    bitu_alu #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_alu (
        .cls   (cls),
        .inv   (inv),
        .opnd  (opnd),
        .sel   (bit_idx[SEL_W-1:0]),
        .c_in  (c_in),
        .nbyte (nbyte),
        .wr    (wr),
        .nc    (nc),
        .c_upd (c_upd),
        .nz    (nz),
        .z_upd (z_upd)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (op_valid) state_nx = ST_RESULT;
            ST_RESULT: if (!op_valid) state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Output register: data held between requests, enables are one-cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_byte  <= '0;
            res_wr    <= 1'b0;
            res_c     <= 1'b0;
            res_c_upd <= 1'b0;
            res_z     <= 1'b0;
            res_z_upd <= 1'b0;
        end else if (op_valid) begin
            res_byte  <= nbyte;
            res_wr    <= wr;
            res_c     <= nc;
            res_c_upd <= c_upd;
            res_z     <= nz;
            res_z_upd <= z_upd;
        end else begin
            res_wr    <= 1'b0;
            res_c_upd <= 1'b0;
            res_z_upd <= 1'b0;
        end
    end

    assign res_valid = (state == ST_RESULT);

endmodule

// File: rtl/bitu_core_chk.sv
module bitu_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opnd,
    input logic              c_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_byte,
    input logic              res_wr,
    input logic              res_c,
    input logic              res_c_upd,
    input logic              res_z_upd
);
    p_result_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    p_single_bit_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> $countones(res_byte ^ $past(opnd)) <= 1);

    p_byte_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_wr) |-> res_byte == $past(opnd));

    p_carry_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_c_upd) |-> res_c == $past(c_in));

    p_reserved_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op_code) >= 4'd14) |-> !(res_wr || res_c_upd || res_z_upd));

    p_enables_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_wr, res_c_upd, res_z_upd}));

    p_enables_need_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_wr || res_c_upd || res_z_upd));
endmodule

bind bitu_core bitu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd      (opnd),
    .c_in      (c_in),
    .res_valid (res_valid),
    .res_byte  (res_byte),
    .res_wr    (res_wr),
    .res_c     (res_c),
    .res_c_upd (res_c_upd),
    .res_z_upd (res_z_upd)
);

// File: tb/bitu_core_bench.sv
module bitu_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] opnd = '0;
    logic [3:0] bit_idx = '0;
    logic       c_in = 1'b0;
    logic       res_valid;
    logic [7:0] res_byte;
    logic       res_wr, res_c, res_c_upd, res_z, res_z_upd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bitu_core u_bitu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd(opnd), .bit_idx(bit_idx), .c_in(c_in), .res_valid(res_valid),
        .res_byte(res_byte), .res_wr(res_wr), .res_c(res_c),
        .res_c_upd(res_c_upd), .res_z(res_z), .res_z_upd(res_z_upd)
    );

    // Reference: {byte, wr, c, c_upd, z_upd, z} from the requirement text.
    function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] b,
                                          input logic [3:0] idx, input logic c);
        logic [2:0] p;
        logic [7:0] nb;
        logic w, nc, cu, zu, nz, bv;
        p = idx[2:0];
        bv = b[p];
        nb = b; w = 0; nc = c; cu = 0; zu = 0; nz = 0;
        if (op == 4'd0) begin nb[p] = 1'b1; w = 1; end
        else if (op == 4'd1) begin nb[p] = 1'b0; w = 1; end
        else if (op == 4'd2) begin nb[p] = !bv; w = 1; end
        else if (op == 4'd3) begin zu = 1; nz = !bv; end
        else if (op == 4'd4) begin nc = bv; cu = 1; end
        else if (op == 4'd5) begin nc = !bv; cu = 1; end
        else if (op == 4'd6) begin nb[p] = c; w = 1; end
        else if (op == 4'd7) begin nb[p] = !c; w = 1; end
        else if (op == 4'd8) begin nc = c && bv; cu = 1; end
        else if (op == 4'd9) begin nc = c && !bv; cu = 1; end
        else if (op == 4'd10) begin nc = c || bv; cu = 1; end
        else if (op == 4'd11) begin nc = c || !bv; cu = 1; end
        else if (op == 4'd12) begin nc = c != bv; cu = 1; end
        else if (op == 4'd13) begin nc = c != !bv; cu = 1; end
        return {nb, w, nc, cu, zu, nz};
    endfunction

    function automatic logic [12:0] observed();
        return {res_byte, res_wr, res_c, res_c_upd, res_z_upd, res_z_upd ? res_z : 1'b0};
    endfunction

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] b,
                          input logic [3:0] idx, input logic c);
        @(negedge clk);
        op_valid = 1; op_code = op; opnd = b; bit_idx = idx; c_in = c;
        @(negedge clk);
        op_valid = 0;
        check_bit(req, res_valid, 1'b1);
        check(req, observed(), model(op, b, idx, c));
    endtask

    task automatic t_reset_r1();
        check_bit("R1 reset valid", res_valid, 1'b0);
        check_bit("R1 reset wr", res_wr, 1'b0);
        check_bit("R1 reset cupd", res_c_upd | res_z_upd, 1'b0);
    endtask

    task automatic t_modify_r3();
        for (int i = 0; i < 8; i++) begin
            run_op("R3 set", 4'd0, 8'h00, 4'(i), 1'b0);
            run_op("R3 clr", 4'd1, 8'hFF, 4'(i), 1'b1);
            run_op("R3 flip", 4'd2, 8'hA5, 4'(i), 1'b0);
        end
    endtask

    task automatic t_test_r4();
        run_op("R4 test one", 4'd3, 8'h10, 4'd4, 1'b1);
        run_op("R4 test zero", 4'd3, 8'hEF, 4'd4, 1'b0);
        check_bit("R4 z value", res_z, 1'b1);
    endtask

    task automatic t_load_r5();
        for (int c = 0; c < 2; c++) begin
            run_op("R5 load", 4'd4, 8'h80, 4'd7, 1'(c));
            run_op("R5 iload", 4'd5, 8'h80, 4'd7, 1'(c));
            run_op("R5 load0", 4'd4, 8'h7F, 4'd7, 1'(c));
        end
    endtask

    task automatic t_store_r6();
        for (int c = 0; c < 2; c++) begin
            run_op("R6 store", 4'd6, 8'h5A, 4'd1, 1'(c));
            run_op("R6 istore", 4'd7, 8'h5A, 4'd2, 1'(c));
        end
    endtask

    task automatic t_logic_r7();
        for (int op = 8; op < 14; op++)
            for (int c = 0; c < 2; c++)
                for (int b = 0; b < 2; b++)
                    run_op("R7 logic", 4'(op), b ? 8'h04 : 8'hFB, 4'd2, 1'(c));
    endtask

    task automatic t_wrap_r2();
        run_op("R2 wrap set", 4'd0, 8'h00, 4'd11, 1'b0);
        check("R2 byte", {res_byte, 5'd0}, {8'h08, 5'd0});
        run_op("R2 wrap load", 4'd4, 8'h02, 4'd9, 1'b0);
        run_op("R2 wrap flip", 4'd2, 8'hFF, 4'd15, 1'b0);
    endtask

    task automatic t_passthru_r8();
        run_op("R8 nowb", 4'd10, 8'h3C, 4'd0, 1'b1);
        check("R8 byte kept", {res_byte, 5'd0}, {8'h3C, 5'd0});
        run_op("R8 carry kept", 4'd0, 8'h3C, 4'd0, 1'b1);
        check_bit("R8 c", res_c, 1'b1);
    endtask

    task automatic t_reserved_r9();
        run_op("R9 code14", 4'd14, 8'hC3, 4'd3, 1'b1);
        run_op("R9 code15", 4'd15, 8'h00, 4'd0, 1'b0);
    endtask

    task automatic t_chain_r1();
        @(negedge clk);
        op_valid = 1; op_code = 4'd0; opnd = 8'h00; bit_idx = 4'd5; c_in = 0;
        @(negedge clk);
        check("R1 chain first", observed(), model(4'd0, 8'h00, 4'd5, 1'b0));
        op_code = 4'd4; opnd = 8'h20; bit_idx = 4'd5; c_in = 0;
        @(negedge clk);
        op_valid = 0;
        check_bit("R1 chain valid", res_valid, 1'b1);
        check("R1 chain second", observed(), model(4'd4, 8'h20, 4'd5, 1'b0));
        @(negedge clk);
        check_bit("R1 drain valid", res_valid, 1'b0);
        check_bit("R10 drain enables", res_wr | res_c_upd | res_z_upd, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1;
        t_modify_r3();
        t_test_r4();
        t_load_r5();
        t_store_r6();
        t_logic_r7();
        t_wrap_r2();
        t_passthru_r8();
        t_reserved_r9();
        t_chain_r1();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule